// File: doc/BRIEF.md
# Interconnect Target Agent Register Block

This block holds the configuration and status registers of a single target agent on an on-chip peripheral interconnect. A simple register bus reaches three 32-bit words. The first is a fixed identifier word. The second is a control word that keeps only a few of the bits written to it. The third is a status word whose bit 0 latches a request-timeout event.

Any control write with bit 0 set acts as a reset command for the agent's interface. It clears the latched timeout flag and is not itself stored. Accesses that are not full words, that hit an undecoded offset, or that write to a read-only word are rejected and reported on an error output. Read data and the error flag both appear one cycle after the strobe.

Alongside the registers, the block computes the absolute base address of the agent's window. It adds the offset of a selected region, taken from a parameter table, to the interconnect base address. It reports a region index outside the table.

Top module: `tagent_regs`

## Requirements
- R1: After reset, the control word reads 0x00000200, the status word reads 0x00000000, and rsp_rdata and rsp_err are 0.
- R2: A word read at offset 0x00 returns the parameter ID_WORD. Its default, 0x54414754, holds four ASCII bytes with the first character in bits 31:24.
- R3: A word write at offset 0x20 stores the written data ANDed with 0x01000700, so only bits 24 and 10:8 are kept. Bit 0 always reads back as 0.
- R4: A word write at offset 0x20 with bit 0 set clears status bit 0.
- R5: A one-cycle timeout_pulse sets status bit 0, which reads at offset 0x28. If the pulse and a clearing control write fall in the same cycle, the bit ends up set.
- R6: rsp_rdata and rsp_err are registered. They reflect the access strobed on the previous rising edge. In a cycle after which no access was strobed, both are 0.
- R7: req_size encodes 0 as byte, 1 as halfword, 2 as word and 3 as reserved. Any access whose size is not 2 raises rsp_err. Such a read returns 0, and such a write changes nothing.
- R8: A read from any offset other than 0x00, 0x20 or 0x28 returns 0 and raises rsp_err. A write to such an offset changes nothing and raises rsp_err.
- R9: A word write to offset 0x00 or 0x28 raises rsp_err and leaves the identifier and status contents unchanged.
- R10: win_base equals icn_base plus the offset of region region_sel. When region_sel is NREG or above, region_err is 1 and win_base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | ADDR_W | Byte offset of the register access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| timeout_pulse | input | 1 | Request-timeout event, one cycle |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered access error |
| icn_base | input | BASE_W | Interconnect base address |
| region_sel | input | RSEL_W | Region index for the window |
| win_base | output | BASE_W | Absolute window base address |
| region_err | output | 1 | Region index out of range |

## Verification
The bench uses the default parameters: NREG of 4 with a 3-bit region_sel. With these, indices 4 to 7 can be driven, so the out-of-range path of the window calculation is exercised next to all four valid regions. An 8-bit ADDR_W puts undecoded offsets such as 0x04 and 0x24 within reach. The four non-overlapping default region offsets make any mix-up of table entries visible.

// File: rtl/tagent_pkg.sv
package tagent_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_CTRL,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ctrl;
        logic err;
        sel_e sel;
    } acc_s;

    localparam logic [31:0] CTRL_KEEP = 32'h0100_0700;
    localparam logic [31:0] CTRL_INIT = 32'h0000_0200;
    localparam int unsigned OFS_IDENT = 32'h00;
    localparam int unsigned OFS_CTRL  = 32'h20;
    localparam int unsigned OFS_STAT  = 32'h28;

    function automatic logic [31:0] pack_tag(input logic [7:0] c0, input logic [7:0] c1,
                                             input logic [7:0] c2, input logic [7:0] c3);
        return {c0, c1, c2, c3};
    endfunction

endpackage

// File: rtl/tagent_decode.sv
module tagent_decode
    import tagent_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        size,
    output acc_s              acc
);
    logic width_ok;
    logic ro_hit;
    sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(OFS_IDENT))     sel = SEL_IDENT;
        else if (addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        else                                sel = SEL_NONE;
    end

    assign width_ok = (size == SZ_WORD);
    assign ro_hit   = (sel == SEL_IDENT) || (sel == SEL_STAT);

    always_comb begin
        acc.sel     = sel;
        acc.rd_ok   = rd && width_ok && (sel != SEL_NONE);
        acc.wr_ctrl = wr && width_ok && (sel == SEL_CTRL);
        acc.err     = (rd || wr) &&
                      (!width_ok || (sel == SEL_NONE) || (wr && ro_hit));
    end
endmodule

// File: rtl/tagent_store.sv
module tagent_store
    import tagent_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    input  logic        timeout_pulse,
    output logic [31:0] ctrl_word,
    output logic        stat_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= CTRL_INIT;
            stat_flag <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_word <= wdata & CTRL_KEEP;
            if (timeout_pulse)             stat_flag <= 1'b1;
            else if (wr_ctrl && wdata[0])  stat_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tagent_window.sv
module tagent_window #(
    parameter int                     BASE_W     = 32,
    parameter int                     NREG       = 4,
    parameter int                     RSEL_W     = 3,
    parameter logic [NREG*BASE_W-1:0] REGION_OFS = '0
) (
    input  logic [BASE_W-1:0] icn_base,
    input  logic [RSEL_W-1:0] region_sel,
    output logic [BASE_W-1:0] win_base,
    output logic              region_err
);
    logic [BASE_W-1:0] ofs [NREG];
    logic [NREG-1:0]   hit;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign ofs[i] = REGION_OFS[i*BASE_W +: BASE_W];
        assign hit[i] = (32'(region_sel) == i);
    end

    always_comb begin
        win_base   = '0;
        region_err = (hit == '0);
        for (int i = 0; i < NREG; i++)
            if (hit[i]) win_base = icn_base + ofs[i];
    end
endmodule

// File: rtl/tagent_regs.sv
module tagent_regs
    import tagent_pkg::*;
#(
    parameter int                     ADDR_W     = 8,
    parameter int                     BASE_W     = 32,
    parameter int                     NREG       = 4,
    parameter int                     RSEL_W     = 3,
    parameter logic [31:0]            ID_WORD    = pack_tag("T", "A", "G", "T"),
    parameter logic [NREG*BASE_W-1:0] REGION_OFS = {32'h0004_0000, 32'h0002_2000,
                                                    32'h0001_0000, 32'h0000_0800}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              timeout_pulse,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [BASE_W-1:0] icn_base,
    input  logic [RSEL_W-1:0] region_sel,
    output logic [BASE_W-1:0] win_base,
    output logic              region_err
);
    acc_s        acc;
    logic [31:0] ctrl_word;
    logic        stat_flag;
    logic [31:0] rd_mux;

    tagent_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .rd(req_rd), .wr(req_wr), .size(req_size), .acc(acc)
    );

    tagent_store u_store (
        .clk(clk), .rst(rst), .wr_ctrl(acc.wr_ctrl), .wdata(req_wdata),
        .timeout_pulse(timeout_pulse), .ctrl_word(ctrl_word), .stat_flag(stat_flag)
    );

    tagent_window #(
        .BASE_W(BASE_W), .NREG(NREG), .RSEL_W(RSEL_W), .REGION_OFS(REGION_OFS)
    ) u_win (
        .icn_base(icn_base), .region_sel(region_sel),
        .win_base(win_base), .region_err(region_err)
    );

    always_comb begin
        unique case (acc.sel)
            SEL_IDENT: rd_mux = ID_WORD;
            SEL_CTRL:  rd_mux = ctrl_word;
            SEL_STAT:  rd_mux = {31'b0, stat_flag};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_rdata <= acc.rd_ok ? rd_mux : '0;
            rsp_err   <= acc.err;
        end
    end
endmodule

// File: rtl/tagent_chk.sv
module tagent_chk
    import tagent_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] ID_WORD = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_rd,
    input logic              req_wr,
    input logic [1:0]        req_size,
    input logic              timeout_pulse,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [31:0]       ctrl_word,
    input logic              stat_flag
);
    // R6
    err_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $past(req_rd || req_wr));

    // R2
    ident_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_addr == ADDR_W'(OFS_IDENT) && req_size == SZ_WORD)
        |=> rsp_rdata == ID_WORD);

    // R5
    timeout_set_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> stat_flag);

    // R7
    bad_width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr && req_size != SZ_WORD) |=> $stable(ctrl_word));

    // R3
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word & ~CTRL_KEEP) == 32'h0);
endmodule

bind tagent_regs tagent_chk #(.ADDR_W(ADDR_W), .ID_WORD(ID_WORD)) u_chk (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
    .req_size(req_size), .timeout_pulse(timeout_pulse), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ctrl_word(ctrl_word), .stat_flag(stat_flag)
);

// File: tb/tagent_regs_tb.sv
module tagent_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_addr = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        timeout_pulse = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] icn_base = '0;
    logic [2:0]  region_sel = '0;
    logic [31:0] win_base;
    logic        region_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tagent_regs u_dut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
        .req_size(req_size), .req_wdata(req_wdata), .timeout_pulse(timeout_pulse),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .icn_base(icn_base),
        .region_sel(region_sel), .win_base(win_base), .region_err(region_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] exp_d, input logic exp_e, input string req);
        @(negedge clk);
        req_addr = a; req_size = sz; req_rd = 1'b1;
        @(posedge clk); #2;
        check(req, rsp_rdata, exp_d);
        check(req, 32'(rsp_err), 32'(exp_e));
        @(negedge clk);
        req_rd = 1'b0; req_size = 2'd2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic exp_e, input string req);
        @(negedge clk);
        req_addr = a; req_size = sz; req_wdata = d; req_wr = 1'b1;
        @(posedge clk); #2;
        check(req, 32'(rsp_err), 32'(exp_e));
        @(negedge clk);
        req_wr = 1'b0; req_size = 2'd2;
    endtask

    task automatic pulse_timeout();
        @(negedge clk); timeout_pulse = 1'b1;
        @(negedge clk); timeout_pulse = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", rsp_rdata, 32'h0);
        check("R1 err", 32'(rsp_err), 32'h0);
        rd(8'h20, 2'd2, 32'h0000_0200, 1'b0, "R1 ctrl");
        rd(8'h28, 2'd2, 32'h0, 1'b0, "R1 stat");
    endtask

    task automatic t_ident();
        rd(8'h00, 2'd2, 32'h5441_4754, 1'b0, "R2 ident");
        // R6: no strobe in the cycle just gone, outputs return to 0
        @(posedge clk); #2;
        check("R6 idle rdata", rsp_rdata, 32'h0);
        check("R6 idle err", 32'(rsp_err), 32'h0);
    endtask

    task automatic t_ctrl();
        wr(8'h20, 2'd2, 32'hFFFF_FFFE, 1'b0, "R3 write");
        rd(8'h20, 2'd2, 32'h0100_0700, 1'b0, "R3 masked");
        wr(8'h20, 2'd2, 32'h0000_0501, 1'b0, "R3 write bit0");
        rd(8'h20, 2'd2, 32'h0000_0500, 1'b0, "R3 bit0 reads 0");
    endtask

    task automatic t_timeout();
        pulse_timeout();
        rd(8'h28, 2'd2, 32'h1, 1'b0, "R5 set");
        wr(8'h20, 2'd2, 32'h0000_0001, 1'b0, "R4 write");
        rd(8'h28, 2'd2, 32'h0, 1'b0, "R4 cleared");
        @(negedge clk);
        req_addr = 8'h20; req_size = 2'd2; req_wdata = 32'h1; req_wr = 1'b1; timeout_pulse = 1'b1;
        @(negedge clk);
        req_wr = 1'b0; timeout_pulse = 1'b0;
        rd(8'h28, 2'd2, 32'h1, 1'b0, "R5 set wins");
    endtask

    task automatic t_width();
        wr(8'h20, 2'd2, 32'h0000_0100, 1'b0, "R7 setup");
        wr(8'h20, 2'd0, 32'h0100_0600, 1'b1, "R7 byte write err");
        wr(8'h20, 2'd1, 32'h0100_0600, 1'b1, "R7 half write err");
        wr(8'h20, 2'd3, 32'h0000_0001, 1'b1, "R7 rsvd write err");
        rd(8'h20, 2'd2, 32'h0000_0100, 1'b0, "R7 ctrl unchanged");
        rd(8'h28, 2'd2, 32'h1, 1'b0, "R7 stat unchanged");
        rd(8'h20, 2'd1, 32'h0, 1'b1, "R7 half read");
        rd(8'h00, 2'd0, 32'h0, 1'b1, "R7 byte read");
    endtask

    task automatic t_bad_ofs();
        rd(8'h24, 2'd2, 32'h0, 1'b1, "R8 read 0x24");
        rd(8'h04, 2'd2, 32'h0, 1'b1, "R8 read 0x04");
        wr(8'h04, 2'd2, 32'hFFFF_FFFF, 1'b1, "R8 write 0x04");
        rd(8'h20, 2'd2, 32'h0000_0100, 1'b0, "R8 ctrl unchanged");
    endtask

    task automatic t_ro();
        wr(8'h00, 2'd2, 32'h1234_5678, 1'b1, "R9 ident write");
        rd(8'h00, 2'd2, 32'h5441_4754, 1'b0, "R9 ident unchanged");
        wr(8'h28, 2'd2, 32'h0, 1'b1, "R9 stat write");
        rd(8'h28, 2'd2, 32'h1, 1'b0, "R9 stat unchanged");
    endtask

    task automatic t_window();
        logic [31:0] ofs [4] = '{32'h0000_0800, 32'h0001_0000, 32'h0002_2000, 32'h0004_0000};
        icn_base = 32'h4800_0000;
        for (int i = 0; i < 4; i++) begin
            region_sel = 3'(i); #1;
            check("R10 base", win_base, 32'h4800_0000 + ofs[i]);
            check("R10 no err", 32'(region_err), 32'h0);
        end
        for (int i = 4; i < 8; i++) begin
            region_sel = 3'(i); #1;
            check("R10 out base", win_base, 32'h0);
            check("R10 out err", 32'(region_err), 32'h1);
        end
    endtask

    initial begin : watchdog
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_ident();
        t_ctrl();
        t_timeout();
        t_width();
        t_bad_ofs();
        t_ro();
        t_window();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule